// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes received Ethernet frames and stores them in a circular region of a byte-wide buffer RAM. Frames arrive one byte per cycle, and the end-of-frame byte carries the frame's error status. The RAM is divided into 256-byte pages. The receive ring is the contiguous range of pages from the start page up to the stop page, with the stop page itself excluded. Frame data goes into the ring page after page. Once the frame has ended, a 4-byte header is written in front of it. The header gives the frame's status, the page where the following frame will begin, and the stored length.

The host frees pages by moving a boundary pointer forward through register writes. The writer never fills the boundary page. When a frame would need that page, the frame is dropped and an overwrite warning is raised. Frames with errors are either kept or discarded, as a configuration bit selects. Three sticky flags are set by received frames, by frames with errors and by overwrite drops. The host clears each flag by writing 1 to it, and the irq output is high while any flag is set.

The RAM itself sits outside the block. The block drives a single byte write port to it.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, the registers read start = 0x01, stop = 0x20, boundary = 0x01, current = 0x01, flags = 0x00 and config = 0x00. irq and mem_we are low.
- R2: The first data byte of a frame is written at byte offset 4 of the current page, and the following bytes go to consecutive addresses. After offset 255 the next byte goes to offset 0 of the next page. The page after (stop − 1) is the start page.
- R3: Header byte 0 (offset 0 of the frame's first page) is the status. Bit 0 is set for a frame with no error. Bit 1 copies rx_err[0] (CRC), bit 2 copies rx_err[1] (alignment) and bit 3 copies rx_err[2] (overrun). Bits 7..4 are 0.
- R4: Header byte 1 is the page after the last page that holds frame data, wrapped as in R2. Header bytes 2 and 3 are the frame length plus 4, low byte first.
- R5: The header is written only after the last data byte, at offsets 0..3 of the frame's first page. Once it is written, current becomes the value in header byte 1. current changes at no other time, apart from host writes.
- R6: A stored frame with no error sets flag bit 0. A stored frame with an error sets flag bit 2 and leaves bit 0 clear.
- R7: When config bit 0 (keep errored frames) is 0, a frame with any rx_err bit set is discarded. No header is written, current is unchanged and flag bit 2 is set.
- R8: A frame is dropped if either of two pages equals the boundary: the page reached when the data crosses a page end, or the next-frame page from R4. A dropped frame gets no header and leaves current unchanged, and flag bit 4 is set.
- R9: Writing 1 to a flag bit at register 4 clears that bit, and writing 0 leaves it set. irq is the OR of the flag bits.
- R10: Register addresses are 0 start, 1 stop, 2 boundary, 3 current, 4 flags and 5 config. Page registers read back what was written. Unused addresses read 0.
- R11: Frame data is never written into the boundary page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_err | input | 3 | Frame errors, valid with rx_last: [0] CRC, [1] alignment, [2] overrun |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| mem_we | output | 1 | Buffer RAM write enable |
| mem_addr | output | 16 | Buffer RAM byte address {page, offset} |
| mem_wdata | output | 8 | Buffer RAM write data |
| irq | output | 1 | High while any flag is set |

## Verification
The checker module tests several properties on every cycle:
- every RAM write falls inside the ring;
- the first byte of a frame lands at offset 4;
- header writes stay on the current page;
- data never enters the boundary page;
- current moves only after a header or a host write;
- a write-one clear of the overwrite flag takes effect.

The contents of the header can only be shown by the bench's frame scenarios, which cover:
- the status bits;
- the next-page value at a page crossing, at an exact page fill and at a wrap;
- the byte count;
- whether a frame is kept, discarded or dropped.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_HDR  = 2'd2
   } wr_state_e;

   localparam int HDR_BYTES = 4;

   localparam logic [2:0] RA_START = 3'd0;
   localparam logic [2:0] RA_STOP  = 3'd1;
   localparam logic [2:0] RA_BND   = 3'd2;
   localparam logic [2:0] RA_CURR  = 3'd3;
   localparam logic [2:0] RA_FLAGS = 3'd4;
   localparam logic [2:0] RA_CFG   = 3'd5;

   localparam int FL_RX  = 0;
   localparam int FL_ERR = 2;
   localparam int FL_OVW = 4;
endpackage

// File: rtl/rxw_page_step.sv
module rxw_page_step #(
   parameter int PAGE_W = 8
) (
   input  logic [PAGE_W-1:0] pg,
   input  logic [PAGE_W-1:0] ring_lo,
   input  logic [PAGE_W-1:0] ring_hi,
   output logic [PAGE_W-1:0] pg_next
);
   logic [PAGE_W-1:0] plus1;
   always_comb begin
      plus1   = pg + PAGE_W'(1);
      pg_next = (plus1 == ring_hi) ? ring_lo : plus1;
   end
endmodule

// File: rtl/rxw_regs.sv
module rxw_regs import rxw_pkg::*; #(
   parameter int               PAGE_W    = 8,
   parameter logic [PAGE_W-1:0] RST_START = 1,
   parameter logic [PAGE_W-1:0] RST_STOP  = 'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              cur_ld,
   input  logic [PAGE_W-1:0] cur_val,
   input  logic              set_rx,
   input  logic              set_err,
   input  logic              set_ovw,
   output logic [PAGE_W-1:0] start_pg,
   output logic [PAGE_W-1:0] stop_pg,
   output logic [PAGE_W-1:0] bnd_pg,
   output logic [PAGE_W-1:0] cur_pg,
   output logic              keep_err,
   output logic [7:0]        flags
);
   logic f_rx, f_err, f_ovw;
   logic clr_hit;

   assign clr_hit = wr && (addr == RA_FLAGS);
   assign flags   = {3'b000, f_ovw, 1'b0, f_err, 1'b0, f_rx};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_pg <= RST_START;
         stop_pg  <= RST_STOP;
         bnd_pg   <= RST_START;
         cur_pg   <= RST_START;
         keep_err <= 1'b0;
         f_rx     <= 1'b0;
         f_err    <= 1'b0;
         f_ovw    <= 1'b0;
      end else begin
         if (wr && addr == RA_START) start_pg <= wdata[PAGE_W-1:0];
         if (wr && addr == RA_STOP)  stop_pg  <= wdata[PAGE_W-1:0];
         if (wr && addr == RA_BND)   bnd_pg   <= wdata[PAGE_W-1:0];
         if (wr && addr == RA_CFG)   keep_err <= wdata[0];
         if (cur_ld)                        cur_pg <= cur_val;
         else if (wr && addr == RA_CURR)    cur_pg <= wdata[PAGE_W-1:0];
         f_rx  <= set_rx  | (f_rx  & ~(clr_hit & wdata[FL_RX]));
         f_err <= set_err | (f_err & ~(clr_hit & wdata[FL_ERR]));
         f_ovw <= set_ovw | (f_ovw & ~(clr_hit & wdata[FL_OVW]));
      end
   end

   always_comb begin
      case (addr)
         RA_START: rdata = 8'(start_pg);
         RA_STOP:  rdata = 8'(stop_pg);
         RA_BND:   rdata = 8'(bnd_pg);
         RA_CURR:  rdata = 8'(cur_pg);
         RA_FLAGS: rdata = flags;
         RA_CFG:   rdata = {7'd0, keep_err};
         default:  rdata = 8'd0;
      endcase
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer import rxw_pkg::*; #(
   parameter int                PAGE_W    = 8,
   parameter int                OFF_W     = 8,
   parameter logic [PAGE_W-1:0] RST_START = 1,
   parameter logic [PAGE_W-1:0] RST_STOP  = 'h20
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_valid,
   input  logic [7:0]              rx_data,
   input  logic                    rx_last,
   input  logic [2:0]              rx_err,
   input  logic                    reg_wr,
   input  logic [2:0]              reg_addr,
   input  logic [7:0]              reg_wdata,
   output logic [7:0]              reg_rdata,
   output logic                    mem_we,
   output logic [PAGE_W+OFF_W-1:0] mem_addr,
   output logic [7:0]              mem_wdata,
   output logic                    irq
);
   localparam int               ADDR_W    = PAGE_W + OFF_W;
   localparam int               CNT_W     = 16;
   localparam logic [OFF_W-1:0] FIRST_OFF = OFF_W'(HDR_BYTES);
   localparam logic [OFF_W-1:0] OFF_LAST  = '1;

   if (PAGE_W < 2 || PAGE_W > 8) begin : g_bad_page
      $error("PAGE_W must be between 2 and 8");
   end
   if (OFF_W < 3) begin : g_bad_off
      $error("OFF_W must leave room for the header");
   end
   if (ADDR_W > CNT_W) begin : g_bad_span
      $error("ring span exceeds the byte count field");
   end

   wr_state_e         st;
   logic [PAGE_W-1:0] wr_pg, h_next;
   logic [OFF_W-1:0]  wr_off;
   logic [CNT_W-1:0]  cnt, cnt_base, cnt_nxt, hdr_cnt;
   logic [1:0]        hidx;
   logic [7:0]        h_stat;
   logic              dropping, h_err;

   logic [PAGE_W-1:0] start_pg, stop_pg, bnd_pg, cur_pg, a_pg, step_pg;
   logic [OFF_W-1:0]  a_off;
   logic              keep_err, idle, take, off_wrap, hit_bnd, was_drop;
   logic              drop_nxt, end_drop, any_err, discard, hdr_done;
   logic              set_rx, set_err, set_ovw;
   logic [7:0]        flags;

   rxw_regs #(.PAGE_W(PAGE_W), .RST_START(RST_START), .RST_STOP(RST_STOP)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .cur_ld(hdr_done), .cur_val(h_next), .set_rx(set_rx),
      .set_err(set_err), .set_ovw(set_ovw), .start_pg(start_pg), .stop_pg(stop_pg),
      .bnd_pg(bnd_pg), .cur_pg(cur_pg), .keep_err(keep_err), .flags(flags)
   );

   rxw_page_step #(.PAGE_W(PAGE_W)) u_step (
      .pg(a_pg), .ring_lo(start_pg), .ring_hi(stop_pg), .pg_next(step_pg)
   );

   always_comb begin
      idle     = (st == ST_IDLE);
      a_pg     = idle ? cur_pg : wr_pg;
      a_off    = idle ? FIRST_OFF : wr_off;
      take     = rx_valid && (st != ST_HDR);
      was_drop = !idle && dropping;
      off_wrap = (a_off == OFF_LAST);
      hit_bnd  = (step_pg == bnd_pg);
      drop_nxt = was_drop || (off_wrap && hit_bnd);
      end_drop = was_drop || hit_bnd;
      any_err  = |rx_err;
      discard  = any_err && !keep_err;
      cnt_base = idle ? '0 : cnt;
      cnt_nxt  = cnt_base + CNT_W'(1);
      hdr_cnt  = cnt + CNT_W'(HDR_BYTES);
      hdr_done = (st == ST_HDR) && (hidx == 2'd3);
      set_rx   = hdr_done && !h_err;
      set_err  = (hdr_done && h_err) || (take && rx_last && !end_drop && discard);
      set_ovw  = take && rx_last && end_drop;
      mem_we   = (take && !was_drop) || (st == ST_HDR);
      if (st == ST_HDR) begin
         mem_addr = {cur_pg, OFF_W'(hidx)};
         case (hidx)
            2'd0:    mem_wdata = h_stat;
            2'd1:    mem_wdata = 8'(h_next);
            2'd2:    mem_wdata = hdr_cnt[7:0];
            default: mem_wdata = hdr_cnt[15:8];
         endcase
      end else begin
         mem_addr  = {a_pg, a_off};
         mem_wdata = rx_data;
      end
   end

   assign irq = |flags;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         wr_pg    <= '0;
         wr_off   <= '0;
         cnt      <= '0;
         dropping <= 1'b0;
         hidx     <= 2'd0;
         h_stat   <= 8'd0;
         h_next   <= '0;
         h_err    <= 1'b0;
      end else if (st == ST_HDR) begin
         hidx <= hidx + 2'd1;
         if (hidx == 2'd3) st <= ST_IDLE;
      end else if (take) begin
         cnt      <= cnt_nxt;
         dropping <= drop_nxt;
         wr_off   <= a_off + OFF_W'(1);
         wr_pg    <= off_wrap ? step_pg : a_pg;
         if (!rx_last) begin
            st <= ST_DATA;
         end else if (end_drop || discard) begin
            st <= ST_IDLE;
         end else begin
            st     <= ST_HDR;
            hidx   <= 2'd0;
            h_stat <= {4'd0, rx_err, ~any_err};
            h_next <= step_pg;
            h_err  <= any_err;
         end
      end
   end
endmodule

// File: rtl/rxw_chk.sv
module rxw_chk import rxw_pkg::*; #(
   parameter int PAGE_W = 8,
   parameter int OFF_W  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input wr_state_e               st,
   input logic                    mem_we,
   input logic [PAGE_W+OFF_W-1:0] mem_addr,
   input logic                    reg_wr,
   input logic [2:0]              reg_addr,
   input logic [7:0]              reg_wdata,
   input logic [PAGE_W-1:0]       start_pg,
   input logic [PAGE_W-1:0]       stop_pg,
   input logic [PAGE_W-1:0]       bnd_pg,
   input logic [PAGE_W-1:0]       cur_pg,
   input logic [7:0]              flags,
   input logic                    set_ovw,
   input logic                    hdr_done
);
   localparam int ADDR_W = PAGE_W + OFF_W;
   logic [PAGE_W-1:0] w_pg;
   assign w_pg = mem_addr[ADDR_W-1:OFF_W];

   // R2
   ring_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && start_pg < stop_pg) |-> (w_pg >= start_pg && w_pg < stop_pg));

   // R2
   first_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && st == ST_IDLE) |-> (mem_addr[OFF_W-1:0] == OFF_W'(HDR_BYTES)));

   // R5
   hdr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && st == ST_HDR) |-> (w_pg == cur_pg && mem_addr[OFF_W-1:0] < OFF_W'(HDR_BYTES)));

   // R5
   curr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_wr && reg_addr == RA_CURR) && !$past(hdr_done)) |-> $stable(cur_pg));

   // R11
   bnd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && st == ST_DATA) |-> (w_pg != bnd_pg));

   // R9
   ovw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_wr && reg_addr == RA_FLAGS && reg_wdata[FL_OVW]) && !$past(set_ovw))
      |-> !flags[FL_OVW]);
endmodule

bind rx_ring_writer rxw_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .mem_we(mem_we), .mem_addr(mem_addr),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg),
   .flags(flags), .set_ovw(set_ovw), .hdr_done(hdr_done)
);

// File: tb/sim_rx_ring_writer.sv
module sim_rx_ring_writer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_last = 1'b0;
   logic [7:0]  rx_data = 8'd0;
   logic [2:0]  rx_err = 3'd0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [7:0]  reg_rdata;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        irq;

   int checks = 0, errors = 0;
   bit done = 0;
   int r_start = 1, r_stop = 6, r_bnd = 0, exp_curr = 1, exp_flags = 0;
   logic [7:0] bmem [2048];

   // {length, rx_err, keep errored frames}
   localparam logic [19:0] VECS [6] = '{
      {16'd60,  3'b000, 1'b0},
      {16'd300, 3'b000, 1'b0},
      {16'd252, 3'b000, 1'b0},
      {16'd10,  3'b001, 1'b0},
      {16'd400, 3'b000, 1'b0},
      {16'd30,  3'b100, 1'b1}
   };

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_ring_writer u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_last(rx_last), .rx_err(rx_err), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
   );

   initial for (int i = 0; i < 2048; i++) bmem[i] = 8'h00;
   always @(posedge clk) if (mem_we) bmem[mem_addr[10:0]] <= mem_wdata;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   function automatic int inc(input int p);
      return (p + 1 == r_stop) ? r_start : p + 1;
   endfunction

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'(seed * 37 + i * 3 + 1);
   endfunction

   task automatic run_frame(input int len, input logic [2:0] err, input bit keep,
                            input int seed, input bit clr);
      int pg, off, nxt, bad;
      bit drop, disc;
      logic [7:0] h0_before, b0_before, b4_before, v;
      wr_reg(3'd5, {7'd0, keep});
      pg = exp_curr; off = 4; drop = 0;
      for (int i = 0; i < len; i++) begin
         off++;
         if (off == 256) begin off = 0; pg = inc(pg); if (pg == r_bnd) drop = 1; end
      end
      nxt = (off == 0) ? pg : inc(pg);
      if (nxt == r_bnd) drop = 1;
      disc = !drop && (err != 0) && !keep;
      h0_before = bmem[exp_curr*256];
      b0_before = (r_bnd < 8) ? bmem[r_bnd*256] : 8'h00;
      b4_before = (r_bnd < 8) ? bmem[r_bnd*256+4] : 8'h00;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = pat(seed, i);
         rx_last = (i == len - 1); rx_err = (i == len - 1) ? err : 3'd0;
      end
      @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; rx_err = 3'd0;
      repeat (8) @(negedge clk);
      if (drop) begin
         exp_flags |= 8'h10;
         chk(bmem[exp_curr*256] == h0_before, "R8", "dropped frame header", bmem[exp_curr*256], h0_before);
         if (r_bnd < 8)
            chk(bmem[r_bnd*256] == b0_before && bmem[r_bnd*256+4] == b4_before, "R11",
                "boundary page untouched", bmem[r_bnd*256+4], b4_before);
      end else if (disc) begin
         exp_flags |= 8'h04;
         chk(bmem[exp_curr*256] == h0_before, "R7", "discarded frame header", bmem[exp_curr*256], h0_before);
      end else begin
         exp_flags |= (err != 0) ? 8'h04 : 8'h01;
         v = {4'd0, err, (err == 3'd0)};
         chk(bmem[exp_curr*256] == v, "R3", "status byte", bmem[exp_curr*256], v);
         chk(bmem[exp_curr*256+1] == 8'(nxt), "R4", "next page byte", bmem[exp_curr*256+1], nxt);
         chk({bmem[exp_curr*256+3], bmem[exp_curr*256+2]} == 16'(len + 4), "R4", "byte count",
             {bmem[exp_curr*256+3], bmem[exp_curr*256+2]}, len + 4);
         pg = exp_curr; off = 4; bad = 0;
         for (int i = 0; i < len; i++) begin
            if (bmem[pg*256+off] != pat(seed, i)) bad++;
            off++;
            if (off == 256) begin off = 0; pg = inc(pg); end
         end
         chk(bad == 0, "R2", "data bytes mismatched", bad, 0);
         exp_curr = nxt;
      end
      rd_reg(3'd3, v);
      chk(v == 8'(exp_curr), "R5", "current page", v, exp_curr);
      rd_reg(3'd4, v);
      chk(v == 8'(exp_flags), "R6", "flags", v, exp_flags);
      if (clr) begin wr_reg(3'd4, 8'hFF); exp_flags = 0; end
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(irq == 1'b0 && mem_we == 1'b0, "R1", "irq/mem_we after reset", {irq, mem_we}, 0);
      rd_reg(3'd0, v); chk(v == 8'h01, "R1", "start reset", v, 1);
      rd_reg(3'd1, v); chk(v == 8'h20, "R1", "stop reset", v, 8'h20);
      rd_reg(3'd2, v); chk(v == 8'h01, "R1", "boundary reset", v, 1);
      rd_reg(3'd3, v); chk(v == 8'h01, "R1", "current reset", v, 1);
      rd_reg(3'd4, v); chk(v == 8'h00, "R1", "flags reset", v, 0);
      rd_reg(3'd5, v); chk(v == 8'h00, "R1", "config reset", v, 0);
      // R10 register map
      wr_reg(3'd1, 8'd6); wr_reg(3'd2, 8'd0); wr_reg(3'd0, 8'd1); wr_reg(3'd3, 8'd1);
      rd_reg(3'd1, v); chk(v == 8'd6, "R10", "stop readback", v, 6);
      rd_reg(3'd2, v); chk(v == 8'd0, "R10", "boundary readback", v, 0);
      rd_reg(3'd7, v); chk(v == 8'd0, "R10", "unused address", v, 0);
      // vector table: page crossing, exact page fill, discard, wrap, kept error
      for (int k = 0; k < 6; k++)
         run_frame(int'(VECS[k][19:4]), VECS[k][3:1], VECS[k][0], k + 1, 1'b1);
      // R8 drop at a page crossing, then at the next-page check
      r_bnd = 4; wr_reg(3'd2, 8'd4);
      run_frame(300, 3'b000, 1'b0, 11, 1'b1);
      run_frame(100, 3'b000, 1'b0, 12, 1'b1);
      // R3 kept alignment error
      r_bnd = 0; wr_reg(3'd2, 8'd0);
      run_frame(20, 3'b010, 1'b1, 13, 1'b1);
      // single-byte frame, then a drop at the wrap; flags accumulate
      run_frame(1, 3'b000, 1'b0, 14, 1'b0);
      r_bnd = 1; wr_reg(3'd2, 8'd1);
      run_frame(1, 3'b000, 1'b0, 15, 1'b0);
      // R9 write-one clear per bit and irq
      chk(irq == 1'b1, "R9", "irq with flags set", irq, 1);
      wr_reg(3'd4, 8'h10);
      rd_reg(3'd4, v); chk(v == 8'h01, "R9", "partial clear", v, 1);
      chk(irq == 1'b1, "R9", "irq with one flag", irq, 1);
      wr_reg(3'd4, 8'h01);
      rd_reg(3'd4, v); chk(v == 8'h00, "R9", "full clear", v, 0);
      chk(irq == 1'b0, "R9", "irq cleared", irq, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule